// File: doc/BRIEF.md
# Header Field Drop Filter

This block decides, in the same cycle, whether a packet should be discarded. It looks at header fields that an upstream parser has already pulled out: two protocol flags (one for TCP, one for UDP), a 4-bit IP version, an 8-bit hop count (time-to-live) and a 16-bit length in bytes. Four rules are checked side by side. If any one of them is broken, the drop output goes high.

Each rule's verdict is also brought out on its own pin, so integration and test logic can see why a packet was rejected. A registered copy of the decision, delayed by one rising clock edge and cleared by a synchronous active-low reset, is provided for paths where the decision must be launched from a flop. A parameter can remove that copy. The block does not parse headers, check checksums or remove packet data.

Top module: `hdr_rule_filter`

## Requirements
- R1: `verBad` is 1 exactly when `ipVer` is neither 4 nor 6. Versions 4 and 6 pass this rule.
- R2: `hopBad` is 1 exactly when `hopCount` is 0. Any value from 1 to 255 passes this rule.
- R3: `sizeBad` is 1 exactly when `pktLen` is greater than 1500. A length of exactly 1500 passes this rule.
- R4: `protoBad` is 1 exactly when both `isTcp` and `isUdp` are 0. One flag set, or both set, passes this rule.
- R5: `dropNow` is the OR of the four rule flags. A packet passes (`dropNow` = 0) only when all four rules are met.
- R6: `dropNow` and the four rule flags depend only on the present inputs. A given input pattern always gives the same outputs, whatever came before.
- R7: With `rstN` high, `dropQ` takes the value `dropNow` had just before each rising edge of `clk`.
- R8: A rising edge of `clk` with `rstN` low clears `dropQ` to 0, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered decision |
| rstN | input | 1 | Synchronous reset, active low |
| isTcp | input | 1 | Packet carries TCP |
| isUdp | input | 1 | Packet carries UDP |
| ipVer | input | 4 | IP version field |
| hopCount | input | 8 | Time-to-live value |
| pktLen | input | 16 | Packet length in bytes |
| dropNow | output | 1 | Combinational drop decision, active high |
| dropQ | output | 1 | Drop decision registered one edge later |
| verBad | output | 1 | Version rule broken |
| hopBad | output | 1 | Hop-count rule broken |
| sizeBad | output | 1 | Length rule broken |
| protoBad | output | 1 | Protocol rule broken |

## Verification
The only state is the registered copy of the decision. A fault there shows up on `dropQ` at the first sampling point after the next rising edge. It appears either as a lag or lead against the previous cycle's `dropNow`, or as a 1 that outlives a reset edge. Faults in the rule logic are combinational. They appear on the matching rule pin and on `dropNow` within the same cycle as the input that triggers them. For that reason the bench sweeps the edges of each rule: versions 3, 4, 5, 6 and 7, hop counts 0 and 1, lengths 1500 and 1501, and all four combinations of the protocol flags.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  // One strobe per rule, raised when that rule is broken.
  typedef struct packed {
    logic verBad;
    logic hopBad;
    logic sizeBad;
    logic protoBad;
  } ruleHits_t;

endpackage

// File: rtl/hrf_rule_eval.sv
module hrf_rule_eval
  import hrf_pkg::*;
#(
  parameter int VER_W   = 4,
  parameter int HOP_W   = 8,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1500,
  parameter int MIN_HOP = 1,
  parameter int VER_A   = 4,
  parameter int VER_B   = 6
) (
  input  logic             isTcp,
  input  logic             isUdp,
  input  logic [VER_W-1:0] ipVer,
  input  logic [HOP_W-1:0] hopCount,
  input  logic [LEN_W-1:0] pktLen,
  output ruleHits_t        hits
);

  localparam int VER_N = 1 << VER_W;
  localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);
  localparam logic [HOP_W-1:0] HOP_FLOOR = HOP_W'(MIN_HOP);

  // Allowed-version mask, one bit per version code.
  logic [VER_N-1:0] verAllow;

  for (genvar v = 0; v < VER_N; v++) begin : g_verMask
    assign verAllow[v] = (v == VER_A) || (v == VER_B);
  end

  always_comb begin
    hits.verBad   = !verAllow[ipVer];
    hits.hopBad   = hopCount < HOP_FLOOR;
    hits.sizeBad  = pktLen > LEN_LIMIT;
    hits.protoBad = !(isTcp || isUdp);
  end

endmodule

// File: rtl/hrf_decide.sv
module hrf_decide
  import hrf_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  ruleHits_t hits,
  output logic      dropNow,
  output logic      dropQ
);

  assign dropNow = hits.verBad | hits.hopBad | hits.sizeBad | hits.protoBad;

  if (REG_OUT) begin : g_reg
    logic dropReg;
    always_ff @(posedge clk) begin
      if (!rstN) dropReg <= 1'b0;
      else       dropReg <= dropNow;
    end
    assign dropQ = dropReg;
  end else begin : g_noReg
    assign dropQ = 1'b0;
  end

endmodule

// File: rtl/hdr_rule_filter.sv
module hdr_rule_filter
  import hrf_pkg::*;
#(
  parameter int VER_W   = 4,
  parameter int HOP_W   = 8,
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 1500,
  parameter int MIN_HOP = 1,
  parameter int VER_A   = 4,
  parameter int VER_B   = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             isTcp,
  input  logic             isUdp,
  input  logic [VER_W-1:0] ipVer,
  input  logic [HOP_W-1:0] hopCount,
  input  logic [LEN_W-1:0] pktLen,
  output logic             dropNow,
  output logic             dropQ,
  output logic             verBad,
  output logic             hopBad,
  output logic             sizeBad,
  output logic             protoBad
);

  ruleHits_t hits;

  hrf_rule_eval #(
    .VER_W(VER_W), .HOP_W(HOP_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
    .MIN_HOP(MIN_HOP), .VER_A(VER_A), .VER_B(VER_B)
  ) u_eval (
    .isTcp(isTcp), .isUdp(isUdp), .ipVer(ipVer),
    .hopCount(hopCount), .pktLen(pktLen), .hits(hits)
  );

  hrf_decide #(.REG_OUT(REG_OUT)) u_decide (
    .clk(clk), .rstN(rstN), .hits(hits), .dropNow(dropNow), .dropQ(dropQ)
  );

  assign verBad   = hits.verBad;
  assign hopBad   = hits.hopBad;
  assign sizeBad  = hits.sizeBad;
  assign protoBad = hits.protoBad;

endmodule

// File: rtl/hrf_checker.sv
module hrf_checker #(
  parameter int VER_W = 4,
  parameter int HOP_W = 8,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             isTcp,
  input logic             isUdp,
  input logic [VER_W-1:0] ipVer,
  input logic [HOP_W-1:0] hopCount,
  input logic [LEN_W-1:0] pktLen,
  input logic             dropNow,
  input logic             dropQ,
  input logic             verBad,
  input logic             hopBad,
  input logic             sizeBad,
  input logic             protoBad
);

  assert_ver_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ipVer == VER_W'(4) || ipVer == VER_W'(6)) |-> !verBad);

  assert_ver_fail_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ipVer == VER_W'(5)) |-> (verBad && dropNow));

  assert_hop_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hopCount == '0) |-> (hopBad && dropNow));

  assert_size_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pktLen == LEN_W'(1500)) |-> !sizeBad);

  assert_proto_none_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!isTcp && !isUdp) |-> (protoBad && dropNow));

  assert_drop_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    dropNow |-> (verBad || hopBad || sizeBad || protoBad));

  assert_drop_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dropQ == $past(dropNow)));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> !dropQ);

endmodule

bind hdr_rule_filter hrf_checker #(.VER_W(VER_W), .HOP_W(HOP_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .isTcp(isTcp), .isUdp(isUdp), .ipVer(ipVer),
  .hopCount(hopCount), .pktLen(pktLen), .dropNow(dropNow), .dropQ(dropQ),
  .verBad(verBad), .hopBad(hopBad), .sizeBad(sizeBad), .protoBad(protoBad)
);

// File: tb/hdr_rule_filter_test.sv
`timescale 1ns/1ps
module hdr_rule_filter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isTcp = 1'b0, isUdp = 1'b0;
  logic [3:0]  ipVer = 4'd0;
  logic [7:0]  hopCount = 8'd0;
  logic [15:0] pktLen = 16'hFFFF;
  logic        dropNow, dropQ, verBad, hopBad, sizeBad, protoBad;

  int total = 0;
  int bad = 0;
  logic prevExp = 1'b0;
  logic prevValid = 1'b0;

  always #5 clk = ~clk;

  hdr_rule_filter uut (
    .clk(clk), .rstN(rstN), .isTcp(isTcp), .isUdp(isUdp), .ipVer(ipVer),
    .hopCount(hopCount), .pktLen(pktLen), .dropNow(dropNow), .dropQ(dropQ),
    .verBad(verBad), .hopBad(hopBad), .sizeBad(sizeBad), .protoBad(protoBad)
  );

  function automatic logic expVer(input logic [3:0] v);
    return !(v == 4'd4 || v == 4'd6);
  endfunction
  function automatic logic expHop(input logic [7:0] h);
    return h == 8'd0;
  endfunction
  function automatic logic expSize(input logic [15:0] l);
    return l > 16'd1500;
  endfunction
  function automatic logic expProto(input logic t, input logic u);
    return !t && !u;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b (ver=%0d hop=%0d len=%0d tcp=%b udp=%b)",
               req, act, exp, ipVer, hopCount, pktLen, isTcp, isUdp);
    end
  endtask

  // Drive one pattern at a falling edge, check the registered value from the
  // previous pattern first, then the combinational outputs 1 ns later.
  task automatic apply(input logic t, input logic u, input logic [3:0] v,
                       input logic [7:0] h, input logic [15:0] l);
    logic e;
    @(negedge clk);
    if (prevValid) check("R7", dropQ, prevExp);
    isTcp = t; isUdp = u; ipVer = v; hopCount = h; pktLen = l;
    #1;
    check("R1", verBad, expVer(v));
    check("R2", hopBad, expHop(h));
    check("R3", sizeBad, expSize(l));
    check("R4", protoBad, expProto(t, u));
    e = expVer(v) | expHop(h) | expSize(l) | expProto(t, u);
    check("R5", dropNow, e);
    prevExp = e;
    prevValid = 1'b1;
  endtask

  initial begin : watchdog
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd17));
    // R8: reset with inputs that would drop.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", dropQ, 1'b0);
    rstN = 1'b1;

    // Directed corners.
    apply(1, 0, 4'd4, 8'd1, 16'd1500);   // all rules met
    apply(0, 1, 4'd6, 8'd255, 16'd0);
    apply(1, 1, 4'd4, 8'd64, 16'd40);    // both flags: R4 satisfied
    apply(0, 0, 4'd4, 8'd64, 16'd40);    // no protocol
    apply(1, 0, 4'd4, 8'd64, 16'd1501);  // just over limit
    apply(1, 0, 4'd4, 8'd0, 16'd100);    // zero hop count
    apply(1, 0, 4'd3, 8'd9, 16'd100);
    apply(1, 0, 4'd5, 8'd9, 16'd100);
    apply(1, 0, 4'd7, 8'd9, 16'd100);
    apply(1, 0, 4'd0, 8'd9, 16'd100);
    apply(1, 0, 4'd15, 8'd9, 16'd100);
    apply(0, 0, 4'd9, 8'd0, 16'hFFFF);   // everything broken
    apply(0, 1, 4'd6, 8'd1, 16'd1500);   // back to pass

    // R6: same pattern after different histories gives the same result.
    apply(0, 0, 4'd2, 8'd0, 16'd9000);
    apply(1, 0, 4'd6, 8'd2, 16'd1400);
    apply(1, 0, 4'd6, 8'd2, 16'd1400);
    check("R6", dropNow, 1'b0);

    // Constrained random.
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  v;
      logic [7:0]  h;
      logic [15:0] l;
      logic t, u;
      v = ($urandom % 3 == 0) ? 4'($urandom) : (($urandom % 2) ? 4'd4 : 4'd6);
      h = ($urandom % 6 == 0) ? 8'd0 : 8'($urandom);
      case ($urandom % 4)
        0: l = 16'd1500 + 16'($urandom % 3) - 16'd1;
        1: l = 16'($urandom);
        default: l = 16'($urandom % 1501);
      endcase
      t = ($urandom % 3) != 0;
      u = ($urandom % 3) != 0;
      apply(t, u, v, h, l);
    end

    // R8: reset in mid-run with a dropping input held.
    apply(0, 0, 4'd1, 8'd0, 16'hFFFF);
    @(negedge clk);
    check("R7", dropQ, 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    check("R8", dropQ, 1'b0);
    rstN = 1'b1;
    prevValid = 1'b0;
    apply(1, 0, 4'd4, 8'd5, 16'd64);
    @(negedge clk);
    check("R7", dropQ, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule